// File: doc/BRIEF.md
# Variable sample rate strobe generator

This block derives sample-enable strobes for several converter channels from one fixed reference clock. Every channel holds its own rate in whole hertz and an optional rational scale factor of 8/7 or 10/7, which reaches the irrational rates that modems use. A phase accumulator per channel adds the scaled rate on every reference tick. Whenever the sum reaches the scaled reference frequency, the accumulator wraps and the channel issues a one-cycle strobe. Because the arithmetic is exact integer arithmetic, the long-term strobe count matches the programmed rate with no drift.

The rate and the multiplier of a channel are written through a per-channel load pulse. A new setting governs the very next tick, so the rate can change in mid-stream without waiting for a period boundary. Playback and capture channels, and the left and right halves of a capture pair, are fully independent.

Top module: `vsr_strobe_gen`

## Requirements
- R1: After reset every channel runs at 48000 Hz with no multiplier, its accumulator is zero and its strobe is low.
- R2: A loaded 16-bit rate word below 7040 is held as 7040, one above 48000 is held as 48000, and any value between them is held unchanged with 1 Hz resolution.
- R3: Each channel has its own rate, multiplier and load bit. A load on one channel leaves the strobes of every other channel unchanged.
- R4: Multiplier code 2'b01 selects 8/7 and code 2'b10 selects 10/7. Codes 2'b00 and 2'b11 select no multiplier. For a ratio N/D, each tick adds N×rate and the wrap threshold is D×FREF_HZ.
- R5: On each tick the sum of the residue and the increment is formed. If the sum is at least the threshold, the threshold is subtracted and the strobe is high for exactly that one cycle. Otherwise the sum is kept and the strobe is low.
- R6: Over any FREF_HZ consecutive ticks, a channel without a multiplier at rate r gives exactly r strobes.
- R7: A load presented at clock edge k is latched at edge k. The tick at edge k still uses the old setting, and every tick from edge k+1 on uses the new one.
- R8: A load that keeps the denominator D keeps the accumulator residue. A load that changes D clears the accumulator at edge k, and no strobe is issued on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at FREF_HZ |
| rst | input | 1 | Synchronous active-high reset |
| rate_word | input | NUM_CH*16 | Rate in hertz per channel; channel c uses bits [16c+15:16c] |
| mult_sel | input | NUM_CH*2 | Multiplier code per channel; channel c uses bits [2c+1:2c] |
| load | input | NUM_CH | Per-channel pulse that latches the rate and multiplier of that channel |
| strobe | output | NUM_CH | Per-channel sample-enable pulse |

## Verification
A strobe belongs to the tick at the clock edge that drives it. A load latched at edge k first shapes the tick at edge k+1, and the clear caused by a change of denominator shows at edge k itself. The bench reference model advances once per rising edge, using the old setting for that tick before it applies any load. It then compares every strobe at the falling edge that follows, so each result is checked in exactly the cycle the requirements assign to it. The exact-count check counts the FREF_HZ ticks from edge k+1 through edge k+FREF_HZ after the load edge.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    localparam int RATE_W   = 16;
    localparam int RATE_MIN = 7040;
    localparam int RATE_MAX = 48000;
    localparam int RATE_DEF = 48000;
    localparam int NUM_MAX  = 10;
    localparam int DEN_MAX  = 7;

    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [1:0] {
        MULT_NONE     = 2'b00,
        MULT_8_OVER_7 = 2'b01,
        MULT_10_OVER_7 = 2'b10,
        MULT_NONE_ALT = 2'b11
    } mult_e;

    typedef struct packed {
        rate_t rate;
        mult_e mult;
    } chan_cfg_t;

    function automatic logic [3:0] mult_num(mult_e m);
        case (m)
            MULT_8_OVER_7:  return 4'd8;
            MULT_10_OVER_7: return 4'd10;
            default:        return 4'd1;
        endcase
    endfunction

    function automatic logic [2:0] mult_den(mult_e m);
        case (m)
            MULT_8_OVER_7, MULT_10_OVER_7: return 3'd7;
            default:                       return 3'd1;
        endcase
    endfunction

    function automatic rate_t clamp_rate(rate_t raw);
        if (raw < rate_t'(RATE_MIN)) return rate_t'(RATE_MIN);
        if (raw > rate_t'(RATE_MAX)) return rate_t'(RATE_MAX);
        return raw;
    endfunction

endpackage

// File: rtl/vsr_rate_reg.sv
module vsr_rate_reg
    import vsr_pkg::*;
#(
    parameter int FREF_HZ = 12288000,
    parameter int ACC_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  rate_t            rate_in,
    input  logic [1:0]       mult_in,
    output logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] modulus,
    output logic             restart
);

    chan_cfg_t cfg_q;
    chan_cfg_t cfg_d;

    always_comb begin
        cfg_d.rate = clamp_rate(rate_in);
        cfg_d.mult = mult_e'(mult_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.rate <= rate_t'(RATE_DEF);
            cfg_q.mult <= MULT_NONE;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        inc     = ACC_W'(cfg_q.rate) * ACC_W'(mult_num(cfg_q.mult));
        modulus = ACC_W'(FREF_HZ) * ACC_W'(mult_den(cfg_q.mult));
        restart = load && (mult_den(cfg_d.mult) != mult_den(cfg_q.mult));
    end

    // R2: the held rate never leaves the legal range
    a_r2_rate_in_range: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rate >= rate_t'(RATE_MIN)) && (cfg_q.rate <= rate_t'(RATE_MAX)));

    // R7: a load is latched at its own edge, clamped
    a_r7_load_latched: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg_q.rate == clamp_rate($past(rate_in))));

endmodule

// File: rtl/vsr_phase_acc.sv
module vsr_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] inc,
    input  logic [ACC_W-1:0] modulus,
    input  logic             restart,
    output logic             strobe
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = acc_q + inc;
        wrap = (sum >= modulus);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q  <= '0;
            strobe <= 1'b0;
        end else if (wrap) begin
            acc_q  <= sum - modulus;
            strobe <= 1'b1;
        end else begin
            acc_q  <= sum;
            strobe <= 1'b0;
        end
    end

    // R5: the residue always stays below the threshold in force
    a_r5_residue_below_mod: assert property (@(posedge clk) disable iff (rst)
        acc_q < modulus);

    // R8: a change of denominator clears the phase with no strobe
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (acc_q == '0) && !strobe);

endmodule

// File: rtl/vsr_strobe_gen.sv
module vsr_strobe_gen
    import vsr_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int FREF_HZ = 12288000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH*RATE_W-1:0] rate_word,
    input  logic [NUM_CH*2-1:0]      mult_sel,
    input  logic [NUM_CH-1:0]        load,
    output logic [NUM_CH-1:0]        strobe
);

    localparam int ACC_W = $clog2(DEN_MAX * FREF_HZ + NUM_MAX * RATE_MAX) + 1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [ACC_W-1:0] inc;
        logic [ACC_W-1:0] modulus;
        logic             restart;

        vsr_rate_reg #(
            .FREF_HZ (FREF_HZ),
            .ACC_W   (ACC_W)
        ) u_rate (
            .clk     (clk),
            .rst     (rst),
            .load    (load[c]),
            .rate_in (rate_word[c*RATE_W +: RATE_W]),
            .mult_in (mult_sel[c*2 +: 2]),
            .inc     (inc),
            .modulus (modulus),
            .restart (restart)
        );

        vsr_phase_acc #(
            .ACC_W (ACC_W)
        ) u_acc (
            .clk     (clk),
            .rst     (rst),
            .inc     (inc),
            .modulus (modulus),
            .restart (restart),
            .strobe  (strobe[c])
        );
    end

    // R1: strobes are low on the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (strobe == '0));

endmodule

// File: tb/vsr_strobe_gen_bench.sv
module vsr_strobe_gen_bench;

    localparam int  NCH     = 4;
    localparam int  FREF    = 96000;
    localparam time CLK_PER = 10ns;
    localparam int  RW      = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH*RW-1:0] rate_word = '0;
    logic [NCH*2-1:0]  mult_sel = '0;
    logic [NCH-1:0]    load = '0;
    logic [NCH-1:0]    strobe;

    vsr_strobe_gen #(.NUM_CH(NCH), .FREF_HZ(FREF)) u_vsr_strobe_gen (
        .clk(clk), .rst(rst), .rate_word(rate_word),
        .mult_sel(mult_sel), .load(load), .strobe(strobe)
    );

    always #(CLK_PER/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string req   = "R1";

    longint m_rate [NCH];
    longint m_num  [NCH];
    longint m_den  [NCH];
    longint m_acc  [NCH];
    bit     m_str  [NCH];

    function automatic longint ratio_num(logic [1:0] code);
        return (code == 2'b01) ? 8 : (code == 2'b10) ? 10 : 1;
    endfunction

    function automatic longint ratio_den(logic [1:0] code);
        return (code == 2'b01 || code == 2'b10) ? 7 : 1;
    endfunction

    function automatic longint limit(longint r);
        if (r < 7040)  return 7040;
        if (r > 48000) return 48000;
        return r;
    endfunction

    // reference model: one tick per rising edge, old setting first
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_rate[c] = 48000; m_num[c] = 1; m_den[c] = 1;
                m_acc[c] = 0; m_str[c] = 1'b0;
            end else begin
                longint nd;
                nd = ratio_den(mult_sel[c*2 +: 2]);
                if (load[c] && nd != m_den[c]) begin
                    m_acc[c] = 0; m_str[c] = 1'b0;
                end else begin
                    m_acc[c] += m_num[c] * m_rate[c];
                    if (m_acc[c] >= m_den[c] * FREF) begin
                        m_acc[c] -= m_den[c] * FREF;
                        m_str[c] = 1'b1;
                    end else begin
                        m_str[c] = 1'b0;
                    end
                end
                if (load[c]) begin
                    m_rate[c] = limit(longint'(rate_word[c*RW +: RW]));
                    m_num[c]  = ratio_num(mult_sel[c*2 +: 2]);
                    m_den[c]  = nd;
                end
            end
        end
    end

    // compare every channel at each falling edge once reset has been seen
    bit started = 1'b0;
    always @(negedge clk) begin
        if (rst) started = 1'b1;
        if (started && !done) begin
            for (int c = 0; c < NCH; c++) begin
                n_cmp++;
                if (strobe[c] !== m_str[c]) begin
                    n_bad++;
                    $display("FAIL %s ch%0d strobe actual %b expected %b at %0t",
                             req, c, strobe[c], m_str[c], $time);
                end
            end
        end
    end

    task automatic check_count(string tag, int ch, int got, int want);
        n_cmp++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s ch%0d strobe count actual %0d expected %0d", tag, ch, got, want);
        end
    endtask

    task automatic set_ch(int c, int r, logic [1:0] m);
        rate_word[c*RW +: RW] = RW'(r);
        mult_sel[c*2 +: 2]    = m;
        load[c]               = 1'b1;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load = '0;
    endtask

    initial begin
        int cnt [NCH];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet right after reset
        req = "R1";
        n_cmp++;
        if (strobe !== '0) begin
            n_bad++;
            $display("FAIL R1 strobe actual %b expected 0000", strobe);
        end

        // R2 R6: clamp and exact count over FREF ticks; ch2 left at default (R1)
        req = "R6";
        set_ch(0, 44100, 2'b00);
        set_ch(1, 3000, 2'b00);
        set_ch(3, 50000, 2'b00);
        @(posedge clk);
        @(negedge clk);
        load = '0;
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        for (int t = 1; t < FREF; t++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) cnt[c] += int'(strobe[c]);
        end
        @(negedge clk);
        for (int c = 0; c < NCH; c++) cnt[c] += int'(strobe[c]);
        check_count("R6", 0, cnt[0], 44100);
        check_count("R2", 1, cnt[1], 7040);
        check_count("R1", 2, cnt[2], 48000);
        check_count("R2", 3, cnt[3], 48000);

        // R4 R8: multiplier changes restart the phase; code 3 keeps it
        req = "R4";
        set_ch(0, 9600, 2'b01);
        set_ch(1, 11025, 2'b10);
        set_ch(2, 22050, 2'b11);
        pulse_load();
        repeat (15000) @(negedge clk);

        // R7 R8: mid-stream rate changes with the same denominator
        req = "R7";
        set_ch(3, 8000, 2'b00);
        set_ch(1, 47999, 2'b01);
        pulse_load();
        repeat (5000) @(negedge clk);
        req = "R8";
        set_ch(3, 32000, 2'b00);
        pulse_load();
        repeat (3000) @(negedge clk);
        set_ch(0, 16000, 2'b00);
        pulse_load();
        repeat (7000) @(negedge clk);

        // R3: back-to-back loads on one channel only
        req = "R3";
        for (int i = 0; i < 20; i++) begin
            set_ch(2, 7040 + i * 2000, (i % 3 == 0) ? 2'b10 : 2'b00);
            pulse_load();
            repeat (37) @(negedge clk);
        end
        repeat (2000) @(negedge clk);

        // R1: reset again mid-stream
        req = "R1";
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (3000) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PER * 190000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule